// File: doc/BRIEF.md
# Hashed MAC Destination Lookup Engine

This block decides whether a received frame should be taken in, based on its destination address. A request hands over the address. The engine hashes it to a starting slot of an external table using one of two selectable hash functions. It then reads slots one at a time, following the linear-probe collision chain that the table writer built. The walk stops at the first live entry whose stored address equals the key, at an empty slot, or when a programmable probe budget runs out.

The walk produces two results: whether the address was found (match), and whether the frame should be received (hit). On a match, hit comes from the entry's receive flag. On a miss, hit comes from a configurable default. A promiscuous setting forces the accept output high but leaves match and hit exactly as computed. The table is written by other logic. This block only reads it, through a port with one cycle of read latency.

Top module: `macrec_lookup`

## Requirements
- R1: After reset, done, busy and tbl_rd_en are all 0.
- R2: The first probe reads the start slot. For hash selector 0, index bit j is the XOR of every address bit i with i mod IDX_W equal to j. For selector 1, the index is the low IDX_W address bits. This read is issued in the cycle right after the acceptance edge.
- R3: A slot matches only when its valid flag is 1, its skip flag is 0 and its stored address equals the key.
- R4: A valid slot that does not match, including a valid slot whose skip flag is set, sends the walk on to the next index. The index wraps from 2^IDX_W-1 to 0.
- R5: A slot with valid flag 0 ends the walk as a miss.
- R6: A probe limit L ends the walk as a miss after L probes. L=0 means 2^HOP_W probes.
- R7: res_hit equals the slot's receive flag on a match, and cfg_default_hit on a miss.
- R8: res_accept equals res_hit OR cfg_promisc. res_match and res_hit do not depend on cfg_promisc.
- R9: res_idx is the matching slot on a match, and the last probed slot on a miss.
- R10: done pulses for exactly one cycle, at the 2k-th rising edge after the acceptance edge, where k is the number of probes. busy is high from acceptance until that edge. While busy, req_valid and every cfg input are ignored, because the hash selector, default, promiscuous setting and limit are all sampled at acceptance.
- R11: Each probe is exactly one tbl_rd_en pulse. Read data is expected on the cycle after the pulse, and two read pulses are never adjacent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request, taken when busy is 0 |
| req_addr | input | ADDR_W | Destination address to look up |
| cfg_hash_sel | input | 1 | Hash function selector |
| cfg_default_hit | input | 1 | Hit value used on a miss |
| cfg_promisc | input | 1 | Force accept on every frame |
| cfg_hop_limit | input | HOP_W | Probe budget (0 means 2^HOP_W) |
| busy | output | 1 | Lookup in progress |
| tbl_rd_en | output | 1 | Table read strobe |
| tbl_rd_idx | output | IDX_W | Table read index |
| tbl_rd_valid | input | 1 | Read slot: valid flag |
| tbl_rd_skip | input | 1 | Read slot: skip (deleted) flag |
| tbl_rd_recv | input | 1 | Read slot: receive flag |
| tbl_rd_addr | input | ADDR_W | Read slot: stored address |
| done | output | 1 | One-cycle result strobe |
| res_match | output | 1 | Address found |
| res_hit | output | 1 | Receive decision |
| res_accept | output | 1 | Hit or promiscuous |
| res_idx | output | IDX_W | Matching or last probed slot |

## Verification
Each probe takes two edges: one for the read and one to evaluate the returned slot. A lookup of k probes therefore raises done on the 2k-th edge after acceptance, and the results are held from that edge. The bench samples on falling edges, counts them from the acceptance edge, and expects done first at count 2k+1. At every sample where a read strobe is seen, it checks the read index against the expected probe sequence. Once done is seen, the bench checks that done and busy are low on the following falling edge.

// File: rtl/macrec_pkg.sv
package macrec_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_EVAL  = 2'd2
  } macrec_state_e;

  typedef struct packed {
    logic match;
    logic hit;
    logic accept;
  } macrec_verdict_t;

endpackage

// File: rtl/macrec_hash.sv
module macrec_hash #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sel,
  output logic [IDX_W-1:0]  idx
);

  logic [IDX_W-1:0] folded;
  logic [IDX_W-1:0] low_bits;

  // XOR-fold: every address bit lands on index bit (i mod IDX_W)
  always_comb begin
    folded = '0;
    for (int i = 0; i < ADDR_W; i++) begin
      folded[i % IDX_W] = folded[i % IDX_W] ^ addr[i];
    end
  end

  generate
    if (ADDR_W >= IDX_W) begin : g_low_direct
      assign low_bits = addr[IDX_W-1:0];
    end else begin : g_low_pad
      assign low_bits = {{(IDX_W-ADDR_W){1'b0}}, addr};
    end
  endgenerate

  assign idx = sel ? low_bits : folded;

endmodule

// File: rtl/macrec_slot_eval.sv
module macrec_slot_eval #(
  parameter int ADDR_W = 48
) (
  input  logic [ADDR_W-1:0] key,
  input  logic              slot_valid,
  input  logic              slot_skip,
  input  logic              slot_recv,
  input  logic [ADDR_W-1:0] slot_addr,
  output logic              is_match,
  output logic              is_free,
  output logic              recv_flag
);

  logic addr_eq;

  assign addr_eq   = (slot_addr == key);
  assign is_match  = slot_valid & ~slot_skip & addr_eq;
  assign is_free   = ~slot_valid;
  assign recv_flag = slot_recv;

endmodule

// File: rtl/macrec_ctrl.sv
module macrec_ctrl
  import macrec_pkg::*;
#(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 8,
  parameter int HOP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [IDX_W-1:0]  start_idx,
  input  logic              cfg_default_hit,
  input  logic              cfg_promisc,
  input  logic [HOP_W-1:0]  cfg_hop_limit,
  input  logic              ent_match,
  input  logic              ent_free,
  input  logic              ent_recv,
  output logic [ADDR_W-1:0] key,
  output logic              busy,
  output logic              tbl_rd_en,
  output logic [IDX_W-1:0]  tbl_rd_idx,
  output logic              done,
  output logic              res_match,
  output logic              res_hit,
  output logic              res_accept,
  output logic [IDX_W-1:0]  res_idx
);

  localparam logic [HOP_W-1:0] HOP_ONE = HOP_W'(1);
  localparam logic [IDX_W-1:0] IDX_ONE = IDX_W'(1);

  macrec_state_e   state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [HOP_W-1:0] hops_q, hops_d;
  logic [HOP_W-1:0] lim_q;
  logic [ADDR_W-1:0] key_q;
  logic             dflt_q, prom_q;
  logic             take_req, probe_step, finish, last_probe;

  macrec_verdict_t  verd_q, verd_d;
  logic [IDX_W-1:0] ridx_q;
  logic             done_q;

  assign last_probe = (hops_q == (lim_q - HOP_ONE));

  // next-state logic
  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    hops_d     = hops_q;
    take_req   = 1'b0;
    probe_step = 1'b0;
    finish     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          take_req = 1'b1;
          state_d  = ST_FETCH;
          idx_d    = start_idx;
          hops_d   = '0;
        end
      end
      ST_FETCH: state_d = ST_EVAL;
      ST_EVAL: begin
        if (ent_match || ent_free || last_probe) begin
          finish  = 1'b1;
          state_d = ST_IDLE;
        end else begin
          probe_step = 1'b1;
          idx_d      = idx_q + IDX_ONE;
          hops_d     = hops_q + HOP_ONE;
          state_d    = ST_FETCH;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    verd_d.match  = ent_match;
    verd_d.hit    = ent_match ? ent_recv : dflt_q;
    verd_d.accept = verd_d.hit | prom_q;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish;
    end
  end

  // result registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verd_q <= '0;
      ridx_q <= '0;
    end else if (finish) begin
      verd_q <= verd_d;
      ridx_q <= idx_q;
    end
  end

  // walk position
  always_ff @(posedge clk) begin
    if (take_req || probe_step) begin
      idx_q  <= idx_d;
      hops_q <= hops_d;
    end
  end

  // request context sampled at acceptance
  always_ff @(posedge clk) begin
    if (take_req) begin
      key_q  <= req_addr;
      lim_q  <= cfg_hop_limit;
      dflt_q <= cfg_default_hit;
      prom_q <= cfg_promisc;
    end
  end

  assign key        = key_q;
  assign busy       = (state_q != ST_IDLE);
  assign tbl_rd_en  = (state_q == ST_FETCH);
  assign tbl_rd_idx = idx_q;
  assign done       = done_q;
  assign res_match  = verd_q.match;
  assign res_hit    = verd_q.hit;
  assign res_accept = verd_q.accept;
  assign res_idx    = ridx_q;

endmodule

// File: rtl/macrec_lookup.sv
module macrec_lookup #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 8,
  parameter int HOP_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              cfg_hash_sel,
  input  logic              cfg_default_hit,
  input  logic              cfg_promisc,
  input  logic [HOP_W-1:0]  cfg_hop_limit,
  output logic              busy,
  output logic              tbl_rd_en,
  output logic [IDX_W-1:0]  tbl_rd_idx,
  input  logic              tbl_rd_valid,
  input  logic              tbl_rd_skip,
  input  logic              tbl_rd_recv,
  input  logic [ADDR_W-1:0] tbl_rd_addr,
  output logic              done,
  output logic              res_match,
  output logic              res_hit,
  output logic              res_accept,
  output logic [IDX_W-1:0]  res_idx
);

  logic [IDX_W-1:0]  start_idx;
  logic [ADDR_W-1:0] key;
  logic              ent_match, ent_free, ent_recv;

  macrec_hash #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_hash (
    .addr (req_addr),
    .sel  (cfg_hash_sel),
    .idx  (start_idx)
  );

  macrec_slot_eval #(.ADDR_W(ADDR_W)) u_eval (
    .key        (key),
    .slot_valid (tbl_rd_valid),
    .slot_skip  (tbl_rd_skip),
    .slot_recv  (tbl_rd_recv),
    .slot_addr  (tbl_rd_addr),
    .is_match   (ent_match),
    .is_free    (ent_free),
    .recv_flag  (ent_recv)
  );

  macrec_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .HOP_W(HOP_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .req_valid       (req_valid),
    .req_addr        (req_addr),
    .start_idx       (start_idx),
    .cfg_default_hit (cfg_default_hit),
    .cfg_promisc     (cfg_promisc),
    .cfg_hop_limit   (cfg_hop_limit),
    .ent_match       (ent_match),
    .ent_free        (ent_free),
    .ent_recv        (ent_recv),
    .key             (key),
    .busy            (busy),
    .tbl_rd_en       (tbl_rd_en),
    .tbl_rd_idx      (tbl_rd_idx),
    .done            (done),
    .res_match       (res_match),
    .res_hit         (res_hit),
    .res_accept      (res_accept),
    .res_idx         (res_idx)
  );

endmodule

// File: rtl/macrec_lookup_chk.sv
module macrec_lookup_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic tbl_rd_en,
  input logic tbl_rd_valid,
  input logic tbl_rd_skip,
  input logic tbl_rd_recv,
  input logic done,
  input logic res_match,
  input logic res_hit,
  input logic res_accept
);

  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r10_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |=> !tbl_rd_en);

  a_r11_read_in_walk: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_rd_en |-> busy);

  a_r3_live_slot: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_match) |-> ($past(tbl_rd_valid) && !$past(tbl_rd_skip)));

  a_r7_recv_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_match) |-> (res_hit == $past(tbl_rd_recv)));

  a_r8_hit_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_hit) |-> res_accept);

endmodule

bind macrec_lookup macrec_lookup_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .busy         (busy),
  .tbl_rd_en    (tbl_rd_en),
  .tbl_rd_valid (tbl_rd_valid),
  .tbl_rd_skip  (tbl_rd_skip),
  .tbl_rd_recv  (tbl_rd_recv),
  .done         (done),
  .res_match    (res_match),
  .res_hit      (res_hit),
  .res_accept   (res_accept)
);

// File: tb/tb_macrec_lookup.sv
`timescale 1ns/1ps
module tb_macrec_lookup;

  localparam int AW = 48;
  localparam int IW = 8;
  localparam int HW = 4;
  localparam int DEPTH = 1 << IW;

  logic          clk, rst_n;
  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic          cfg_hash_sel, cfg_default_hit, cfg_promisc;
  logic [HW-1:0] cfg_hop_limit;
  logic          busy, tbl_rd_en, done, res_match, res_hit, res_accept;
  logic [IW-1:0] tbl_rd_idx, res_idx;
  logic [AW+2:0] rdq;
  logic [AW+2:0] mem [DEPTH];

  int checks = 0;
  int errors = 0;

  macrec_lookup #(.ADDR_W(AW), .IDX_W(IW), .HOP_W(HW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_hash_sel(cfg_hash_sel), .cfg_default_hit(cfg_default_hit),
    .cfg_promisc(cfg_promisc), .cfg_hop_limit(cfg_hop_limit),
    .busy(busy), .tbl_rd_en(tbl_rd_en), .tbl_rd_idx(tbl_rd_idx),
    .tbl_rd_valid(rdq[AW+2]), .tbl_rd_skip(rdq[AW+1]), .tbl_rd_recv(rdq[AW]),
    .tbl_rd_addr(rdq[AW-1:0]), .done(done), .res_match(res_match),
    .res_hit(res_hit), .res_accept(res_accept), .res_idx(res_idx)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // table model: one cycle read latency
  always_ff @(posedge clk) begin
    if (tbl_rd_en) rdq <= mem[tbl_rd_idx];
  end

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] f_hash(input logic [AW-1:0] a, input logic sel);
    logic [IW-1:0] h;
    if (sel) return a[IW-1:0];
    h = '0;
    for (int i = 0; i < AW; i++) h[i % IW] ^= a[i];
    return h;
  endfunction

  function automatic logic [AW-1:0] rnd_addr();
    return {$urandom(), $urandom()} & {AW{1'b1}};
  endfunction

  task automatic clear_tbl();
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  endtask

  task automatic insert(input logic [AW-1:0] a, input logic sel, input logic recv);
    logic [IW-1:0] ix;
    ix = f_hash(a, sel);
    for (int p = 0; p < DEPTH; p++) begin
      if (!mem[ix][AW+2]) begin
        mem[ix] = {1'b1, 1'b0, recv, a};
        return;
      end
      ix = ix + 1'b1;
    end
  endtask

  task automatic remove(input logic [AW-1:0] a, input logic sel);
    logic [IW-1:0] ix;
    ix = f_hash(a, sel);
    for (int p = 0; p < DEPTH; p++) begin
      if (!mem[ix][AW+2]) return;
      if (!mem[ix][AW+1] && mem[ix][AW-1:0] == a) begin
        mem[ix][AW+1] = 1'b1;
        return;
      end
      ix = ix + 1'b1;
    end
  endtask

  // full lookup with independent expected values (R2..R11)
  task automatic lookup(input logic [AW-1:0] a, input logic sel, input logic dflt,
                        input logic prom, input logic [HW-1:0] lim);
    int lim_n, e_probes, n, seen_rd;
    logic e_match, e_hit, e_acc;
    logic [IW-1:0] ix, e_idx, first_ix;
    logic [AW+2:0] ent;
    bit got;
    lim_n = (lim == 0) ? (1 << HW) : int'(lim);
    first_ix = f_hash(a, sel);
    ix = first_ix;
    e_match = 1'b0;
    e_probes = 0;
    for (int p = 0; p < lim_n; p++) begin
      ent = mem[ix];
      e_probes = p + 1;
      if (ent[AW+2] && !ent[AW+1] && ent[AW-1:0] == a) begin e_match = 1'b1; break; end
      if (!ent[AW+2]) break;
      if (p != lim_n - 1) ix = ix + 1'b1;
    end
    e_idx = ix;
    e_hit = e_match ? mem[ix][AW] : dflt;
    e_acc = e_hit | prom;

    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_addr = a; cfg_hash_sel = sel;
    cfg_default_hit = dflt; cfg_promisc = prom; cfg_hop_limit = lim;
    n = 0; seen_rd = 0; got = 0;
    while (!got && n < 200) begin
      @(negedge clk);
      n++;
      if (tbl_rd_en) begin
        check(tbl_rd_idx == IW'(first_ix + seen_rd), (seen_rd == 0) ? "R2 start slot" : "R4 probe index",
              64'(tbl_rd_idx), 64'(IW'(first_ix + seen_rd)));
        seen_rd++;
      end
      if (done) begin
        got = 1;
        req_valid = 1'b0;
      end else begin
        // R10: traffic and config changes during a walk must be ignored
        req_valid = 1'b1; req_addr = rnd_addr();
        cfg_hash_sel = 1'($urandom()); cfg_default_hit = 1'($urandom());
        cfg_promisc = 1'($urandom()); cfg_hop_limit = HW'($urandom());
      end
    end
    check(got, "R10 done seen", 64'(got), 64'(1));
    check(n == 2 * e_probes + 1, "R10 latency", 64'(n), 64'(2 * e_probes + 1));
    check(seen_rd == e_probes, "R11 reads per walk", 64'(seen_rd), 64'(e_probes));
    check(res_match == e_match, e_match ? "R3 match" : "R5/R6 miss", 64'(res_match), 64'(e_match));
    check(res_hit == e_hit, "R7 hit", 64'(res_hit), 64'(e_hit));
    check(res_accept == e_acc, "R8 accept", 64'(res_accept), 64'(e_acc));
    check(res_idx == e_idx, "R9 index", 64'(res_idx), 64'(e_idx));
    @(negedge clk);
    check(!done, "R10 single-cycle done", 64'(done), 64'(0));
    check(!busy, "R10 idle after done", 64'(busy), 64'(0));
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a1, a2, a3, a4, b3, pool [150];
    void'($urandom(32'd4242));
    req_valid = 0; req_addr = '0; cfg_hash_sel = 0; cfg_default_hit = 0;
    cfg_promisc = 0; cfg_hop_limit = '0;
    clear_tbl();
    rst_n = 0;
    repeat (3) @(negedge clk);
    check(!done && !busy && !tbl_rd_en, "R1 reset state", {61'b0, done, busy, tbl_rd_en}, 64'(0));
    rst_n = 1;
    @(negedge clk);
    check(!done && !busy && !tbl_rd_en, "R1 after release", {61'b0, done, busy, tbl_rd_en}, 64'(0));

    // directed chain at slot 0x10 with a deleted link (R3, R4, R5, R7, R8)
    a1 = 48'hA00000000010; a2 = 48'hA10000000010;
    a3 = 48'hA20000000010; a4 = 48'hA30000000010;
    insert(a1, 1, 1); insert(a2, 1, 1); insert(a3, 1, 0); insert(a4, 1, 1);
    remove(a2, 1);
    lookup(a3, 1, 1, 0, 4'd8);   // R4 passes skipped slot; R7 recv=0 gives no hit
    lookup(a3, 1, 0, 1, 4'd8);   // R8 promiscuous accept, hit stays 0
    lookup(a2, 1, 0, 0, 4'd8);   // R5 deleted address misses at empty 0x14
    lookup(a2, 1, 1, 0, 4'd8);   // R7 default hit on miss
    lookup(a4, 1, 0, 0, 4'd2);   // R6 budget of two probes
    lookup(a1, 1, 0, 0, 4'd1);   // R3 first slot match

    // wrap around top of table (R4)
    insert(48'hB000000000FE, 1, 1); insert(48'hB100000000FE, 1, 1);
    b3 = 48'hB200000000FE; insert(b3, 1, 1);
    lookup(b3, 1, 0, 0, 4'd5);

    // long occupied run with limit 0 (R6)
    for (int i = 0; i < 20; i++) insert({8'hC0, 8'(i), 32'h00000040}, 1, 1);
    lookup(48'hDD0000000040, 1, 0, 0, 4'd0);

    // constrained random over both hash functions
    for (int t = 0; t < 2; t++) begin
      clear_tbl();
      for (int i = 0; i < 150; i++) begin
        pool[i] = rnd_addr();
        insert(pool[i], 1'(t), 1'($urandom()));
      end
      for (int i = 0; i < 30; i++) remove(pool[$urandom_range(149)], 1'(t));
      for (int i = 0; i < 150; i++) begin
        logic [AW-1:0] k;
        k = ($urandom_range(1) == 1) ? pool[$urandom_range(149)] : rnd_addr();
        lookup(k, 1'(t), 1'($urandom()), 1'($urandom()),
               ($urandom_range(9) == 0) ? HW'(0) : HW'($urandom_range(15, 1)));
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule